// File: doc/BRIEF.md
# Embedded-Clock Deserializer Lock Tracker

This block takes a serial stream already sampled once per bit period (one bit per clock) and recovers the framing of a 28-bit word format. Each frame carries a 1-then-0 clock edge pattern, a 24-bit payload and two spare bits. The block finds the bit position where the edge pattern repeats every frame, declares lock once that position has held for several frames in a row, and then delivers each payload word with a one-cycle strobe and a recovered word clock.

Lock is fragile on purpose: one frame without the edge pattern drops it, and the search restarts by itself. A power-down input stops and clears the tracker. Both power-down and output enable model a tri-stated output stage through a drive flag, while the lock flag keeps reporting the tracker state.

Top module: `ecd_lock_tracker`

## Requirements
- R1: Frame bit order on `ser_in` is: bit 0 = 1, bit 1 = 0 (the clock edge), bits 2..25 = payload bit 0 first up to bit 23, bits 26..27 spare and ignored. While locked, `word_out` takes the payload and `word_stb` pulses for one cycle at the clock edge that samples frame bit 25.
- R2: `locked` rises at the edge that samples bit 1 of the LOCK_FRAMES-th consecutive frame (default 4) showing 1-then-0 at the same bit position.
- R3: If bit 1 of a frame is not 0 after a 1 while locked, `locked` falls at the edge that samples that bit.
- R4: While hunting, each failed test moves the tested position one bit later (next test 29 bits on); a passed test retests 28 bits on. Re-locking needs no external command.
- R5: While unlocked, `word_stb` stays low and `word_out` holds the last delivered word.
- R6: With `out_en` low, `outs_driven` is 0 and `word_out`, `word_stb`, `word_clk` read 0; `locked` stays driven and tracking continues unchanged.
- R7: With `pwdn_n` low the outputs behave as in R6, `locked` is 0 from the next edge and the tracker is cleared; after `pwdn_n` returns high the full R2 acquisition is needed again. The last word is kept.
- R8: While locked, `word_clk` is a 28-bit-period clock, high 14 and low 14 bit periods; with `clk_pol` = 0 its rising edge coincides with a `word_out` update, with `clk_pol` = 1 it is inverted so its falling edge does. It is 0 while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial sample, one bit per clock |
| pwdn_n | input | 1 | Active-low power-down |
| out_en | input | 1 | Output enable |
| clk_pol | input | 1 | Recovered clock edge select |
| word_out | output | 24 | Recovered payload word |
| word_stb | output | 1 | One-cycle strobe on a new word |
| word_clk | output | 1 | Recovered word clock |
| outs_driven | output | 1 | 1 when payload and clock outputs are driven |
| locked | output | 1 | Frame lock flag |

## Verification
The sharpest collision is a lost lock landing right after a word has been delivered: the edge test that drops lock falls in the cycle where assembly of the next word would begin. The bench corrupts the edge bit of the frame that directly follows a strobed word and judges, with a behavioural per-cycle model, that no strobe follows, that `word_out` keeps the earlier word and that the recovered clock goes low in the same cycle as the lock flag. Power-down applied while locked and released mid-stream is judged the same way.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

    localparam int FRAME_BITS  = 28;
    localparam int PAY_BITS    = 24;
    localparam int HALF_BITS   = FRAME_BITS / 2;
    localparam int SHIFT_LO    = FRAME_BITS - PAY_BITS;
    localparam int SHIFT_HI    = FRAME_BITS - 1;
    localparam int CLK_HI_FROM = FRAME_BITS - HALF_BITS + SHIFT_LO;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1);

    typedef logic [CNT_W-1:0]    cnt_t;
    typedef logic [PAY_BITS-1:0] word_t;

    localparam cnt_t C_SHIFT_LO    = cnt_t'(SHIFT_LO);
    localparam cnt_t C_SHIFT_HI    = cnt_t'(SHIFT_HI);
    localparam cnt_t C_CLK_HI_FROM = cnt_t'(CLK_HI_FROM);
    localparam cnt_t C_RELOAD_HIT  = cnt_t'(FRAME_BITS - 1);
    localparam cnt_t C_RELOAD_MISS = cnt_t'(FRAME_BITS);

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } trk_state_e;

    // Alignment view shared by the datapath stages
    typedef struct packed {
        cnt_t cnt;     // bits until the next edge test
        logic locked;
    } align_s;

    function automatic logic edge_seen(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    function automatic logic in_shift_window(input cnt_t c);
        return (c >= C_SHIFT_LO) && (c <= C_SHIFT_HI);
    endfunction

    function automatic logic clk_level(input cnt_t c);
        return (c < C_SHIFT_LO) || (c >= C_CLK_HI_FROM);
    endfunction

endpackage

// File: rtl/ecd_edge_hunter.sv
module ecd_edge_hunter
    import ecd_pkg::*;
#(
    parameter int LOCK_FRAMES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   din,
    output align_s al
);
    localparam int MW = $clog2(LOCK_FRAMES + 1);
    localparam logic [MW-1:0] M_LAST = MW'(LOCK_FRAMES - 1);

    trk_state_e    state;
    cnt_t          cnt;
    logic [MW-1:0] match;
    logic          prev;
    logic          at_test;
    logic          hit;

    assign at_test = (cnt == '0);
    assign hit     = edge_seen(prev, din);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= ST_HUNT;
            cnt   <= '0;
            match <= '0;
            prev  <= 1'b0;
        end else begin
            prev <= din;
            if (!at_test) begin
                cnt <= cnt - 1'b1;
            end else if (hit) begin
                cnt <= C_RELOAD_HIT;
                if (state == ST_HUNT) begin
                    if (match == M_LAST) begin
                        state <= ST_LOCK;
                        match <= '0;
                    end else begin
                        match <= match + 1'b1;
                    end
                end
            end else begin
                // slip one bit and start counting again
                cnt   <= C_RELOAD_MISS;
                state <= ST_HUNT;
                match <= '0;
            end
        end
    end

    assign al.cnt    = cnt;
    assign al.locked = (state == ST_LOCK);

endmodule

// File: rtl/ecd_payload_shifter.sv
module ecd_payload_shifter
    import ecd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   din,
    input  align_s al,
    output word_t  data,
    output logic   stb
);
    word_t sr;
    word_t next_sr;
    logic  last_bit;

    assign next_sr  = {din, sr[PAY_BITS-1:1]};
    assign last_bit = (al.cnt == C_SHIFT_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            data <= '0;
            stb  <= 1'b0;
        end else if (clr) begin
            sr  <= '0;
            stb <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (in_shift_window(al.cnt)) begin
                sr <= next_sr;
            end
            if (last_bit && al.locked) begin
                data <= next_sr;
                stb  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecd_out_stage.sv
module ecd_out_stage
    import ecd_pkg::*;
(
    input  align_s al,
    input  logic   drive,
    input  logic   pol,
    input  word_t  data,
    input  logic   stb,
    output word_t  word_out,
    output logic   word_stb,
    output logic   word_clk
);
    logic lvl;

    assign lvl      = clk_level(al.cnt) ^ pol;
    assign word_out = drive ? data : '0;
    assign word_stb = drive & stb;
    assign word_clk = drive & al.locked & lvl;

endmodule

// File: rtl/ecd_lock_tracker.sv
module ecd_lock_tracker
    import ecd_pkg::*;
#(
    parameter int LOCK_FRAMES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_in,
    input  logic                pwdn_n,
    input  logic                out_en,
    input  logic                clk_pol,
    output logic [PAY_BITS-1:0] word_out,
    output logic                word_stb,
    output logic                word_clk,
    output logic                outs_driven,
    output logic                locked
);
    align_s al;
    word_t  data;
    logic   stb;
    logic   clr;

    assign clr         = ~pwdn_n;
    assign outs_driven = pwdn_n & out_en;
    assign locked      = al.locked;

    ecd_edge_hunter #(.LOCK_FRAMES(LOCK_FRAMES)) u_hunt (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .din (ser_in),
        .al  (al)
    );

    ecd_payload_shifter u_shift (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .din  (ser_in),
        .al   (al),
        .data (data),
        .stb  (stb)
    );

    ecd_out_stage u_out (
        .al       (al),
        .drive    (outs_driven),
        .pol      (clk_pol),
        .data     (data),
        .stb      (stb),
        .word_out (word_out),
        .word_stb (word_stb),
        .word_clk (word_clk)
    );

endmodule

// File: rtl/ecd_checker.sv
module ecd_checker (
    input logic        clk,
    input logic        rst,
    input logic        ser_in,
    input logic        pwdn_n,
    input logic        clk_pol,
    input logic [23:0] word_out,
    input logic        word_stb,
    input logic        word_clk,
    input logic        outs_driven,
    input logic        locked
);
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb); // R1

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (outs_driven && $past(outs_driven) && !word_stb) |-> $stable(word_out)); // R5

    AST_STB_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> locked); // R5

    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (!$past(ser_in) && $past(ser_in, 2))); // R2

    AST_PWDN_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        !pwdn_n |=> !locked); // R7

    AST_CLK_EDGE_AT_WORD: assert property (@(posedge clk) disable iff (rst)
        (word_stb && !clk_pol) |-> word_clk); // R8

    AST_CLK_INV_AT_WORD: assert property (@(posedge clk) disable iff (rst)
        (word_stb && clk_pol) |-> !word_clk); // R8

endmodule

bind ecd_lock_tracker ecd_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ser_in      (ser_in),
    .pwdn_n      (pwdn_n),
    .clk_pol     (clk_pol),
    .word_out    (word_out),
    .word_stb    (word_stb),
    .word_clk    (word_clk),
    .outs_driven (outs_driven),
    .locked      (locked)
);

// File: tb/sim_ecd_lock_tracker.sv
`timescale 1ns/1ps
module sim_ecd_lock_tracker;
    localparam int LF = 4;
    localparam int FB = 28;
    localparam int PB = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ser_in = 1'b0;
    logic          pwdn_n = 1'b1;
    logic          out_en = 1'b1;
    logic          clk_pol = 1'b0;
    logic [PB-1:0] word_out;
    logic          word_stb, word_clk, outs_driven, locked;

    always #4 clk = ~clk;

    ecd_lock_tracker #(.LOCK_FRAMES(LF)) u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .pwdn_n(pwdn_n),
        .out_en(out_en), .clk_pol(clk_pol), .word_out(word_out),
        .word_stb(word_stb), .word_clk(word_clk),
        .outs_driven(outs_driven), .locked(locked)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // behavioural reference
    int            m_wait;
    bit            m_lock;
    int            m_run;
    bit            m_prev;
    bit            m_bits[$];
    logic [PB-1:0] m_word;
    bit            m_stb;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_wait = 0; m_lock = 0; m_run = 0; m_prev = 0; m_stb = 0;
        m_bits.delete();
    endtask

    task automatic model_step(input bit b);
        if (!pwdn_n) begin
            model_clear();
            return;
        end
        m_stb = 0;
        if (m_wait == 0) begin
            m_bits.delete();
            if (m_prev && !b) begin
                m_wait = FB - 1;
                if (!m_lock) begin
                    m_run++;
                    if (m_run == LF) begin m_lock = 1; m_run = 0; end
                end
            end else begin
                m_wait = FB; m_lock = 0; m_run = 0;
            end
        end else begin
            m_wait--;
            m_bits.push_back(b);
            if (m_lock && m_bits.size() == PB) begin
                for (int i = 0; i < PB; i++) m_word[i] = m_bits[i];
                m_stb = 1;
            end
        end
        m_prev = b;
    endtask

    task automatic compare_all();
        bit drv = pwdn_n && out_en;
        bit lvl = ((m_wait < FB - PB) || (m_wait >= FB / 2 + FB - PB)) ^ clk_pol;
        logic [PB-1:0] ew = drv ? m_word : '0;
        check(word_out === ew, "R1", "word_out", 32'(word_out), 32'(ew));
        check(word_stb === (drv && m_stb), "R1", "word_stb", 32'(word_stb), 32'(drv && m_stb));
        check(locked === m_lock, "R2", "locked", 32'(locked), 32'(m_lock));
        check(word_clk === (drv && m_lock && lvl), "R8", "word_clk", 32'(word_clk),
              32'(drv && m_lock && lvl));
        check(outs_driven === drv, "R6", "outs_driven", 32'(outs_driven), 32'(drv));
    endtask

    task automatic tick(input bit b);
        ser_in = b;
        @(posedge clk);
        model_step(b);
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [PB-1:0] p, input bit edge_ok, input logic [1:0] sp);
        tick(1'b1);
        tick(edge_ok ? 1'b0 : 1'b1);
        for (int i = 0; i < PB; i++) tick(p[i]);
        tick(sp[0]);
        tick(sp[1]);
    endtask

    task automatic frames_until_lock(input string tag);
        int n = 0;
        while (!locked && n < 60) begin
            send_frame(PB'($urandom), 1'b1, 2'($urandom));
            n++;
        end
        check(locked === 1'b1, tag, "relock", 32'(locked), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R4 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [PB-1:0] last;
        model_clear();
        m_word = '0;
        repeat (3) @(negedge clk);
        check(locked === 1'b0, "R2", "reset locked", 32'(locked), 32'd0);
        check(word_out === '0, "R1", "reset word", 32'(word_out), 32'd0);
        check(word_stb === 1'b0, "R1", "reset stb", 32'(word_stb), 32'd0);
        check(word_clk === 1'b0, "R8", "reset clk", 32'(word_clk), 32'd0);
        rst = 1'b0;

        // acquisition: first test misses, slips to bit 1 of frame 1
        for (int f = 0; f < LF; f++) send_frame(PB'($urandom), 1'b1, 2'b11);
        check(locked === 1'b0, "R2", "not yet locked", 32'(locked), 32'd0);
        send_frame(24'h13579b, 1'b1, 2'b01);
        check(locked === 1'b1, "R2", "locked after run", 32'(locked), 32'd1);
        check(word_out === 24'h13579b, "R1", "first word", 32'(word_out), 32'h13579b);

        send_frame(24'hffffff, 1'b1, 2'b00);
        send_frame(24'h000000, 1'b1, 2'b11);
        send_frame(24'h555555, 1'b1, 2'b10);
        send_frame(24'haaaaaa, 1'b1, 2'b01);
        check(word_out === 24'haaaaaa, "R1", "pattern word", 32'(word_out), 32'haaaaaa);

        clk_pol = 1'b1;                       // R8 inverted clock
        for (int f = 0; f < 3; f++) send_frame(PB'($urandom), 1'b1, 2'b10);
        clk_pol = 1'b0;

        out_en = 1'b0;                        // R6
        send_frame(24'hc0ffee, 1'b1, 2'b00);
        check(outs_driven === 1'b0, "R6", "disabled", 32'(outs_driven), 32'd0);
        check(locked === 1'b1, "R6", "lock kept", 32'(locked), 32'd1);
        out_en = 1'b1;
        #1;
        check(word_out === 24'hc0ffee, "R6", "tracking went on", 32'(word_out), 32'hc0ffee);

        last = 24'h2468ac;
        send_frame(last, 1'b1, 2'b11);
        send_frame(24'h777777, 1'b0, 2'b00);  // R3 missing edge
        check(locked === 1'b0, "R3", "lock dropped", 32'(locked), 32'd0);
        check(word_out === last, "R5", "word held", 32'(word_out), 32'(last));
        frames_until_lock("R4");

        pwdn_n = 1'b0;                        // R7
        for (int i = 0; i < 10; i++) tick(1'($urandom));
        check(locked === 1'b0, "R7", "pwdn unlock", 32'(locked), 32'd0);
        pwdn_n = 1'b1;
        tick(1'b0);
        check(locked === 1'b0, "R7", "after pwdn", 32'(locked), 32'd0);
        frames_until_lock("R7");

        for (int i = 0; i < 13; i++) tick(1'($urandom));
        frames_until_lock("R4");
        for (int f = 0; f < 3; f++) send_frame(PB'($urandom), 1'b1, 2'b01);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule